// File: doc/BRIEF.md
# Audio receiver error flag controller

This block condenses the health of a biphase-mark digital audio receiver into one error flag. It takes several event streams that arrive already decoded: the clock-recovery lock status, a parity verdict for each subframe, a non-PCM indication, the sampling-frequency field taken from each received channel status block, and a measured sample-rate code. It drives the error flag, a mute request for the output data path, a short-run parity indication and a busy signal for its hold timer.

A fault sets the flag. Once every fault has cleared, the flag stays high for a selectable hold time counted on a 1 ms tick. All changes of the flag are aligned to a one-cycle strobe that marks the left/right word clock edge. Two fields are tracked from block to block: the frequency field and the measured rate. A change in either raises the flag and starts the same hold sequence as a lock loss. A rate-tolerant mode turns off both comparisons and the hold time, so that sources with a varying pitch do not flag errors.

Top module: `aud_err_flag_ctl`

## Requirements
- R1: While reset is held and right after it, `err_flag`, `mute_req` and `hold_busy` are 1 and `par_alt` is 0.
- R2: If `pll_locked` is 0 on a cycle where `wstb` is 1, `err_flag` is 1 on the next cycle. `hold_busy` is 1 on the cycle after any cycle with `pll_locked` at 0.
- R3: `err_flag` changes only on the cycle after a cycle with `wstb` at 1.
- R4: After the last fault clears, `hold_busy` drops on the Nth `ms_tick`. N is 3, 24, 48 or 144 for `hold_sel` values 0, 1, 2 and 3. `err_flag` then falls at the next `wstb`.
- R5: A fault that appears while the hold is running restarts the hold count from zero.
- R6: Nine or more consecutive subframes with `par_bad` at 1 (counted on `par_vld`) form a fault. A subframe with good parity clears the run.
- R7: `par_alt` pulses for one cycle, on the cycle after a bad subframe that is the 1st to 8th of its run. It stays 0 from the 9th onward. Such short runs leave `err_flag` at 0.
- R8: On `blk_vld`, `blk_fs` is compared with the previously stored value. The first block after reset is only captured. A differing value raises `err_flag` at the next `wstb`.
- R9: On `rate_vld`, `rate_code` is compared with its previously stored value in the same way, with the same effect.
- R10: With `ign_rate` at 1, mismatches in `blk_fs` and `rate_code` are ignored and no hold time applies. `err_flag` falls at the next `wstb` once lock is present.
- R11: With `npcm_err_en` at 1, `npcm` at 1 sets `mute_req` in the same cycle and raises `err_flag` at the next `wstb`. With `npcm_err_en` at 0, `npcm` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wstb | input | 1 | One-cycle strobe at each word clock edge |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| pll_locked | input | 1 | Clock recovery locked |
| par_vld | input | 1 | Subframe parity verdict valid |
| par_bad | input | 1 | Subframe parity failed |
| npcm | input | 1 | Non-PCM stream detected |
| blk_vld | input | 1 | New channel status block field valid |
| blk_fs | input | 4 | Sampling-frequency field of the block |
| rate_vld | input | 1 | New measured rate code valid |
| rate_code | input | 4 | Measured sample-rate code |
| hold_sel | input | 2 | Hold time select |
| npcm_err_en | input | 1 | Treat non-PCM as an error |
| ign_rate | input | 1 | Ignore rate and frequency changes |
| err_flag | output | 1 | Receiver error flag |
| mute_req | output | 1 | Mute request for output data |
| par_alt | output | 1 | Short-run parity error pulse |
| hold_busy | output | 1 | Hold timer running |

## Verification
The bench builds the block with its default parameters: hold lengths of 3, 24, 48 and 144 ticks, a parity run threshold of nine and 4-bit compare fields. With the millisecond tick driven directly by the bench, even the 144 ms hold completes in a few hundred cycles, so every hold code is reached exactly at its boundary tick. The default nine-deep run lets the bench place the boundary between the eighth and ninth bad subframe.

// File: rtl/aud_err_pkg.sv
package aud_err_pkg;

   // Chooses one of four hold lengths from the 2-bit select
   function automatic int unsigned hold_pick(input logic [1:0] sel,
                                             input int unsigned h0,
                                             input int unsigned h1,
                                             input int unsigned h2,
                                             input int unsigned h3);
      case (sel)
         2'd0:    return h0;
         2'd1:    return h1;
         2'd2:    return h2;
         default: return h3;
      endcase
   endfunction

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/aud_err_parrun.sv
module aud_err_parrun #(
   parameter int unsigned RUN_LIM = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vld,
   input  logic bad,
   output logic run_sat,
   output logic short_pulse
);
   localparam int unsigned CW = $clog2(RUN_LIM + 1);
   localparam logic [CW-1:0] LIM = CW'(RUN_LIM);

   generate
      if (RUN_LIM < 2) begin : g_bad_lim
         $error("aud_err_parrun: RUN_LIM must be at least 2");
      end
   endgenerate

   logic [CW-1:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q       <= '0;
         short_pulse <= 1'b0;
      end else begin
         short_pulse <= vld && bad && (run_q < LIM - CW'(1));
         if (vld) begin
            if (!bad)            run_q <= '0;
            else if (run_q != LIM) run_q <= run_q + CW'(1);
         end
      end
   end

   assign run_sat = (run_q == LIM);
endmodule

// File: rtl/aud_err_cmp.sv
module aud_err_cmp #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld,
   input  logic [W-1:0] val,
   input  logic         en,
   output logic         diff
);
   generate
      if (W < 1) begin : g_bad_w
         $error("aud_err_cmp: W must be positive");
      end
   endgenerate

   logic [W-1:0] prev_q;
   logic         have_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         have_q <= 1'b0;
      end else if (vld) begin
         prev_q <= val;
         have_q <= 1'b1;
      end
   end

   assign diff = vld && have_q && en && (val != prev_q);
endmodule

// File: rtl/aud_err_hold.sv
module aud_err_hold
   import aud_err_pkg::*;
#(
   parameter int unsigned H0 = 3,
   parameter int unsigned H1 = 24,
   parameter int unsigned H2 = 48,
   parameter int unsigned H3 = 144
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fault,
   input  logic       tick,
   input  logic [1:0] sel,
   output logic       busy
);
   localparam int unsigned HMAX = max4(H0, H1, H2, H3);
   localparam int unsigned TW   = $clog2(HMAX + 1);

   generate
      if (H0 < 1 || H1 < 1 || H2 < 1 || H3 < 1) begin : g_bad_hold
         $error("aud_err_hold: hold lengths must be at least one tick");
      end
   endgenerate

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] lim;

   assign lim = TW'(hold_pick(sel, H0, H1, H2, H3));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         busy  <= 1'b1;
      end else if (fault) begin
         cnt_q <= '0;
         busy  <= 1'b1;
      end else if (busy && tick) begin
         if (cnt_q + TW'(1) >= lim) begin
            cnt_q <= '0;
            busy  <= 1'b0;
         end else begin
            cnt_q <= cnt_q + TW'(1);
         end
      end
   end
endmodule

// File: rtl/aud_err_flag_ctl.sv
module aud_err_flag_ctl #(
   parameter int unsigned FS_W    = 4,
   parameter int unsigned RATE_W  = 4,
   parameter int unsigned PAR_RUN = 9,
   parameter int unsigned HOLD_0  = 3,
   parameter int unsigned HOLD_1  = 24,
   parameter int unsigned HOLD_2  = 48,
   parameter int unsigned HOLD_3  = 144
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wstb,
   input  logic              ms_tick,
   input  logic              pll_locked,
   input  logic              par_vld,
   input  logic              par_bad,
   input  logic              npcm,
   input  logic              blk_vld,
   input  logic [FS_W-1:0]   blk_fs,
   input  logic              rate_vld,
   input  logic [RATE_W-1:0] rate_code,
   input  logic [1:0]        hold_sel,
   input  logic              npcm_err_en,
   input  logic              ign_rate,
   output logic              err_flag,
   output logic              mute_req,
   output logic              par_alt,
   output logic              hold_busy
);
   logic run_sat, fs_diff, rate_diff, mm_pend_q, npcm_err, fault, want;

   aud_err_parrun #(.RUN_LIM(PAR_RUN)) u_run (
      .clk(clk), .rst_n(rst_n), .vld(par_vld), .bad(par_bad),
      .run_sat(run_sat), .short_pulse(par_alt)
   );

   aud_err_cmp #(.W(FS_W)) u_fs_cmp (
      .clk(clk), .rst_n(rst_n), .vld(blk_vld), .val(blk_fs),
      .en(!ign_rate), .diff(fs_diff)
   );

   aud_err_cmp #(.W(RATE_W)) u_rate_cmp (
      .clk(clk), .rst_n(rst_n), .vld(rate_vld), .val(rate_code),
      .en(!ign_rate), .diff(rate_diff)
   );

   assign npcm_err = npcm && npcm_err_en;
   assign fault    = !pll_locked || run_sat || npcm_err || mm_pend_q;

   aud_err_hold #(.H0(HOLD_0), .H1(HOLD_1), .H2(HOLD_2), .H3(HOLD_3)) u_hold (
      .clk(clk), .rst_n(rst_n), .fault(fault), .tick(ms_tick),
      .sel(hold_sel), .busy(hold_busy)
   );

   assign want = fault || (hold_busy && !ign_rate);

   // Mismatch stays pending until a word strobe has carried it to the flag
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mm_pend_q <= 1'b0;
         err_flag  <= 1'b1;
      end else begin
         if (fs_diff || rate_diff) mm_pend_q <= 1'b1;
         else if (wstb)            mm_pend_q <= 1'b0;
         if (wstb) err_flag <= want;
      end
   end

   assign mute_req = err_flag || npcm_err;
endmodule

// File: rtl/aud_err_flag_chk.sv
module aud_err_flag_chk (
   input logic clk,
   input logic rst_n,
   input logic wstb,
   input logic pll_locked,
   input logic par_vld,
   input logic par_bad,
   input logic ign_rate,
   input logic err_flag,
   input logic par_alt,
   input logic hold_busy
);
   // R3
   flag_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wstb |=> $stable(err_flag));

   // R2
   lock_loss_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wstb && !pll_locked) |=> err_flag);

   // R2
   lock_loss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_locked |=> hold_busy);

   // R4
   fall_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_flag) |-> ($past(ign_rate) || !$past(hold_busy)));

   // R7
   alt_after_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      par_alt |-> $past(par_vld && par_bad));
endmodule

bind aud_err_flag_ctl aud_err_flag_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wstb(wstb), .pll_locked(pll_locked),
   .par_vld(par_vld), .par_bad(par_bad), .ign_rate(ign_rate),
   .err_flag(err_flag), .par_alt(par_alt), .hold_busy(hold_busy)
);

// File: tb/aud_err_flag_ctl_tb.sv
module aud_err_flag_ctl_tb;
   localparam int CLK_PER = 10;

   logic clk = 0, rst_n = 0, wstb = 0, ms_tick = 0, pll_locked = 1;
   logic par_vld = 0, par_bad = 0, npcm = 0, blk_vld = 0, rate_vld = 0;
   logic [3:0] blk_fs = 0, rate_code = 0;
   logic [1:0] hold_sel = 0;
   logic npcm_err_en = 0, ign_rate = 0;
   logic err_flag, mute_req, par_alt, hold_busy;
   int n_run = 0, n_fail = 0;
   logic done = 0;

   always #(CLK_PER/2) clk = ~clk;

   aud_err_flag_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .wstb(wstb), .ms_tick(ms_tick),
      .pll_locked(pll_locked), .par_vld(par_vld), .par_bad(par_bad),
      .npcm(npcm), .blk_vld(blk_vld), .blk_fs(blk_fs), .rate_vld(rate_vld),
      .rate_code(rate_code), .hold_sel(hold_sel), .npcm_err_en(npcm_err_en),
      .ign_rate(ign_rate), .err_flag(err_flag), .mute_req(mute_req),
      .par_alt(par_alt), .hold_busy(hold_busy)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic step(); @(posedge clk); @(negedge clk); endtask
   task automatic strobe(); wstb = 1; step(); wstb = 0; endtask
   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin ms_tick = 1; step(); ms_tick = 0; step(); end
   endtask
   task automatic clear_hold(input int n); ticks(n); strobe(); endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 flag in reset", err_flag, 1);
      chk("R1 mute in reset", mute_req, 1);
      rst_n = 1; step();
      chk("R1 busy after reset", hold_busy, 1);
      chk("R1 alt after reset", par_alt, 0);
   endtask

   task automatic t_hold(input logic [1:0] sel, input int n);
      hold_sel = sel;
      pll_locked = 0; step(); pll_locked = 1; step();
      strobe();
      ticks(n - 1);
      chk($sformatf("R4 busy before tick %0d", n), hold_busy, 1);
      strobe();
      chk("R4 flag held during hold", err_flag, 1);
      ticks(1);
      chk($sformatf("R4 busy cleared at tick %0d", n), hold_busy, 0);
      chk("R3 flag waits for strobe", err_flag, 1);
      strobe();
      chk("R4 flag falls at strobe", err_flag, 0);
   endtask

   task automatic t_lock();
      hold_sel = 0;
      pll_locked = 0; step();
      chk("R3 no rise without strobe", err_flag, 0);
      chk("R2 busy on lock loss", hold_busy, 1);
      strobe();
      chk("R2 flag on lock loss", err_flag, 1);
      pll_locked = 1; ticks(2);
      pll_locked = 0; step(); pll_locked = 1;
      ticks(2);
      chk("R5 hold restarted", hold_busy, 1);
      ticks(1);
      chk("R5 hold ends after full count", hold_busy, 0);
      strobe();
      chk("R5 flag falls", err_flag, 0);
   endtask

   task automatic t_parity();
      for (int i = 0; i < 8; i++) begin
         par_vld = 1; par_bad = 1; step(); par_vld = 0; par_bad = 0;
         chk($sformatf("R7 alt pulse bad %0d", i + 1), par_alt, 1);
         strobe();
         chk("R7 short run no flag", err_flag, 0);
      end
      par_vld = 1; par_bad = 1; step(); par_vld = 0; par_bad = 0;
      chk("R7 no alt on ninth", par_alt, 0);
      strobe();
      chk("R6 nine bad raise flag", err_flag, 1);
      par_vld = 1; par_bad = 1; step(); par_vld = 0; par_bad = 0;
      chk("R7 no alt past ninth", par_alt, 0);
      par_vld = 1; par_bad = 0; step(); par_vld = 0;
      ticks(3);
      chk("R6 good parity clears run", hold_busy, 0);
      strobe();
      chk("R6 flag falls after run cleared", err_flag, 0);
   endtask

   task automatic t_fs();
      blk_fs = 4'd2; blk_vld = 1; step(); blk_vld = 0; strobe();
      chk("R8 first block captured only", err_flag, 0);
      blk_vld = 1; step(); blk_vld = 0; strobe();
      chk("R8 equal block no flag", err_flag, 0);
      blk_fs = 4'd3; blk_vld = 1; step(); blk_vld = 0;
      chk("R8 waits for strobe", err_flag, 0);
      strobe();
      chk("R8 field change raises", err_flag, 1);
      clear_hold(3);
      chk("R8 recovers", err_flag, 0);
   endtask

   task automatic t_rate();
      rate_code = 4'd5; rate_vld = 1; step(); rate_vld = 0; strobe();
      chk("R9 first rate captured only", err_flag, 0);
      rate_code = 4'd6; rate_vld = 1; step(); rate_vld = 0; strobe();
      chk("R9 rate change raises", err_flag, 1);
      clear_hold(3);
      chk("R9 recovers", err_flag, 0);
   endtask

   task automatic t_ign();
      ign_rate = 1;
      rate_code = 4'd9; rate_vld = 1; step(); rate_vld = 0;
      blk_fs = 4'd7; blk_vld = 1; step(); blk_vld = 0; strobe();
      chk("R10 changes ignored", err_flag, 0);
      pll_locked = 0; step(); strobe();
      chk("R10 lock loss still raises", err_flag, 1);
      pll_locked = 1; step(); strobe();
      chk("R10 falls without hold", err_flag, 0);
      ticks(3);
      ign_rate = 0; strobe();
      chk("R10 back to normal", err_flag, 0);
   endtask

   task automatic t_npcm();
      npcm_err_en = 0; npcm = 1; step();
      chk("R11 npcm ignored mute", mute_req, 0);
      strobe();
      chk("R11 npcm ignored flag", err_flag, 0);
      npcm_err_en = 1; #1;
      chk("R11 mute at once", mute_req, 1);
      @(negedge clk);
      strobe();
      chk("R11 npcm raises flag", err_flag, 1);
      npcm = 0; clear_hold(3);
      chk("R11 recovers", err_flag, 0);
      chk("R11 mute drops", mute_req, 0);
   endtask

   initial begin
      t_reset();
      ticks(3); strobe();
      chk("R4 release after reset", err_flag, 0);
      t_hold(2'd0, 3);
      t_hold(2'd1, 24);
      t_hold(2'd2, 48);
      t_hold(2'd3, 144);
      t_lock();
      t_parity();
      t_fs();
      t_rate();
      t_ign();
      t_npcm();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule